// File: doc/BRIEF.md
# Interrupt Gate Dispatcher

This block turns an interrupt vector into a control-transfer decision by looking up a gate descriptor in a table in memory. Each request carries a vector, the kind of event that raised it (software, hardware or processor exception), and the current privilege level. The table base address and byte limit come from a base/limit register that the block samples at the same time as the request. The block checks the limit and reads the 8-byte gate at `base + vector*8` as two 32-bit memory beats. It decodes the gate, applies the access rules, and returns a single result strobe.

A successful lookup returns the target code selector, the 32-bit handler offset and two control bits. One tells the core to clear its interrupt-enable flag and the other asks for a task switch. A failed lookup returns a fault vector instead: 13 for a protection violation or 11 for a gate that is marked absent. The core then dispatches that fault itself. Stack switching, segment loading and the task switch itself belong to the consumer of the result.

Top module: `gate_dispatch`

## Requirements
- R1: A request is accepted only while `req_ready_o` is high, which is true only when the block is idle; no memory beat is issued and no result is pending while it is high.
- R2: The descriptor is read as two beats, the low word from address `base + vector*8` first and the high word from `base + vector*8 + 4` second. An address stays stable while its beat waits for `mem_req_ready_i`.
- R3: Field layout, with low word L and high word H: handler offset = {H[31:16], L[15:0]}, selector = L[31:16], gate type = H[11:8], system bit = H[12] (must be 0), DPL = H[14:13], present = H[15].
- R4: Types 4'h6 and 4'hE are interrupt gates. They dispatch with `res_if_clear_o`=1 and `res_task_switch_o`=0.
- R5: Types 4'h7 and 4'hF are trap gates. They dispatch with `res_if_clear_o`=0 and `res_task_switch_o`=0.
- R6: Type 4'h5 is a task gate. It dispatches with `res_task_switch_o`=1 and `res_if_clear_o`=0, and the selector and offset are returned as decoded.
- R7: Any other type, or a set system bit, gives fault vector 13.
- R8: For source code 0 (software), CPL greater than the gate DPL gives fault vector 13. Source codes 1 (hardware), 2 and 3 (exception) skip this check.
- R9: If `vector*8+7 > limit`, the result is fault vector 13 and no memory beat is issued.
- R10: A hardware-sourced request whose vector is below 32 (the processor exception range) gives fault vector 13 and no memory beat is issued.
- R11: A gate that passes the type and privilege checks but has present=0 gives fault vector 11. Check priority is: limit or reserved vector, then type, then privilege, then present.
- R12: `res_valid_o` is high for exactly one cycle per request. On a fault, selector, offset, `res_if_clear_o` and `res_task_switch_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| req_ready_o | output | 1 | Block idle, request accepted |
| req_vector_i | input | 8 | Interrupt vector |
| req_src_i | input | 2 | Source: 0 software, 1 hardware, 2/3 exception |
| req_cpl_i | input | 2 | Current privilege level |
| tbl_base_i | input | 32 | Table base address |
| tbl_limit_i | input | 16 | Table limit in bytes (last valid byte offset) |
| mem_req_valid_o | output | 1 | Memory read beat request |
| mem_req_ready_i | input | 1 | Memory accepts beat |
| mem_addr_o | output | 32 | Beat byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| res_valid_o | output | 1 | Result strobe |
| res_fault_o | output | 1 | Result is a fault |
| res_fault_vec_o | output | 8 | Fault vector (11 or 13) |
| res_selector_o | output | 16 | Target selector |
| res_offset_o | output | 32 | Handler offset |
| res_if_clear_o | output | 1 | Clear interrupt-enable flag |
| res_task_switch_o | output | 1 | Task switch requested |

## Verification
A wrong beat address or a swapped word capture shows up in the same result strobe as scrambled selector or offset fields. The first lookup through such a fault exposes it, roughly four cycles after the request. A wrong check order or a stale pre-check flag shows up as the wrong fault vector. It can also show as a memory beat that should never have been issued, which is visible at the memory port during the same lookup. A stuck sequencer shows up as `req_ready_o` staying low, or as a result strobe that lasts longer than one cycle.

// File: rtl/gd_pkg.sv
package gd_pkg;
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned DESC_W   = 64;
  localparam int unsigned BEAT_W   = 32;
  localparam int unsigned EXC_TOP  = 32;
  localparam logic [VEC_W-1:0] VEC_GP = VEC_W'(13);
  localparam logic [VEC_W-1:0] VEC_NP = VEC_W'(11);

  typedef enum logic [1:0] {
    SRC_SW  = 2'd0,
    SRC_HW  = 2'd1,
    SRC_EXC = 2'd2,
    SRC_RSV = 2'd3
  } src_e;

  typedef enum logic [1:0] {GK_INT, GK_TRAP, GK_TASK, GK_BAD} kind_e;

  typedef struct packed {
    logic [15:0] sel;
    logic [31:0] off;
    kind_e       kind;
    logic [1:0]  dpl;
    logic        present;
  } gate_t;

  typedef struct packed {
    logic             fault;
    logic [VEC_W-1:0] fvec;
    logic [15:0]      sel;
    logic [31:0]      off;
    logic             if_clear;
    logic             task_sw;
  } result_t;

  function automatic kind_e classify(logic sys_bit, logic [3:0] typ);
    if (sys_bit) return GK_BAD;
    case (typ)
      4'h5:       return GK_TASK;
      4'h6, 4'hE: return GK_INT;
      4'h7, 4'hF: return GK_TRAP;
      default:    return GK_BAD;
    endcase
  endfunction
endpackage

// File: rtl/gd_fetch.sv
module gd_fetch
  import gd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LIM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VEC_W-1:0]  vector_i,
  input  src_e              src_i,
  input  logic [1:0]        cpl_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LIM_W-1:0]  limit_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [BEAT_W-1:0] mem_rsp_data_i,
  output logic [DESC_W-1:0] desc_o,
  output src_e              src_o,
  output logic [1:0]        cpl_o,
  output logic              pre_fault_o,
  output logic              done_o
);
  localparam int unsigned OFS_W = VEC_W + 3;
  localparam int unsigned CMP_W = (OFS_W > LIM_W) ? OFS_W : LIM_W;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_REQ, S_WAIT, S_DONE} state_e;

  state_e              state_q;
  logic                beat_q;
  logic [VEC_W-1:0]    vec_q;
  src_e                src_q;
  logic [1:0]          cpl_q;
  logic [ADDR_W-1:0]   base_q;
  logic [LIM_W-1:0]    limit_q;
  logic [BEAT_W-1:0]   lo_q, hi_q;
  logic                pre_fault_q;
  logic [CMP_W-1:0]    last_byte, limit_ext;
  logic                over_limit, reserved_hw;

  assign last_byte   = CMP_W'({vec_q, 3'b111});
  assign limit_ext   = CMP_W'(limit_q);
  assign over_limit  = last_byte > limit_ext;
  assign reserved_hw = (src_q == SRC_HW) && (vec_q < VEC_W'(EXC_TOP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      beat_q      <= 1'b0;
      vec_q       <= '0;
      src_q       <= SRC_SW;
      cpl_q       <= '0;
      base_q      <= '0;
      limit_q     <= '0;
      lo_q        <= '0;
      hi_q        <= '0;
      pre_fault_q <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          vec_q       <= vector_i;
          src_q       <= src_i;
          cpl_q       <= cpl_i;
          base_q      <= base_i;
          limit_q     <= limit_i;
          pre_fault_q <= 1'b0;
          beat_q      <= 1'b0;
          state_q     <= S_CHECK;
        end
        S_CHECK: begin
          if (over_limit || reserved_hw) begin
            pre_fault_q <= 1'b1;
            state_q     <= S_DONE;
          end else begin
            state_q <= S_REQ;
          end
        end
        S_REQ: if (mem_req_ready_i) state_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid_i) begin
          if (!beat_q) begin
            lo_q    <= mem_rsp_data_i;
            beat_q  <= 1'b1;
            state_q <= S_REQ;
          end else begin
            hi_q    <= mem_rsp_data_i;
            state_q <= S_DONE;
          end
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == S_IDLE);
  assign mem_req_valid_o = (state_q == S_REQ);
  // vector*8 + beat*4 is a plain concatenation
  assign mem_addr_o      = base_q + ADDR_W'({vec_q, beat_q, 2'b00});
  assign desc_o          = {hi_q, lo_q};
  assign src_o           = src_q;
  assign cpl_o           = cpl_q;
  assign pre_fault_o     = pre_fault_q;
  assign done_o          = (state_q == S_DONE);

  assert_ready_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_req_valid_o && !done_o));

  assert_addr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)));

  assert_one_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/gd_decode.sv
module gd_decode
  import gd_pkg::*;
(
  input  logic [DESC_W-1:0] desc_i,
  output gate_t             gate_o
);
  logic [BEAT_W-1:0] lo, hi;
  logic [7:0]        unused_rsvd;

  assign lo          = desc_i[BEAT_W-1:0];
  assign hi          = desc_i[DESC_W-1:BEAT_W];
  assign unused_rsvd = hi[7:0];

  always_comb begin
    gate_o.off     = {hi[31:16], lo[15:0]};
    gate_o.sel     = lo[31:16];
    gate_o.kind    = classify(hi[12], hi[11:8]);
    gate_o.dpl     = hi[14:13];
    gate_o.present = hi[15];
  end
endmodule

// File: rtl/gd_check.sv
module gd_check
  import gd_pkg::*;
(
  input  gate_t      gate_i,
  input  src_e       src_i,
  input  logic [1:0] cpl_i,
  input  logic       pre_fault_i,
  output result_t    res_o
);
  logic priv_bad;

  assign priv_bad = (src_i == SRC_SW) && (cpl_i > gate_i.dpl);

  always_comb begin
    res_o = '0;
    if (pre_fault_i || gate_i.kind == GK_BAD || priv_bad) begin
      res_o.fault = 1'b1;
      res_o.fvec  = VEC_GP;
    end else if (!gate_i.present) begin
      res_o.fault = 1'b1;
      res_o.fvec  = VEC_NP;
    end else begin
      res_o.sel      = gate_i.sel;
      res_o.off      = gate_i.off;
      res_o.if_clear = (gate_i.kind == GK_INT);
      res_o.task_sw  = (gate_i.kind == GK_TASK);
    end
  end
endmodule

// File: rtl/gate_dispatch.sv
module gate_dispatch
  import gd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LIM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [7:0]        req_vector_i,
  input  logic [1:0]        req_src_i,
  input  logic [1:0]        req_cpl_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [LIM_W-1:0]  tbl_limit_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [31:0]       mem_rsp_data_i,
  output logic              res_valid_o,
  output logic              res_fault_o,
  output logic [7:0]        res_fault_vec_o,
  output logic [15:0]       res_selector_o,
  output logic [31:0]       res_offset_o,
  output logic              res_if_clear_o,
  output logic              res_task_switch_o
);
  logic [DESC_W-1:0] desc;
  src_e              src_q;
  logic [1:0]        cpl_q;
  logic              pre_fault;
  gate_t             gate;
  result_t           res;

  gd_fetch #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) i_fetch (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .vector_i        (req_vector_i),
    .src_i           (src_e'(req_src_i)),
    .cpl_i           (req_cpl_i),
    .base_i          (tbl_base_i),
    .limit_i         (tbl_limit_i),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_addr_o      (mem_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .desc_o          (desc),
    .src_o           (src_q),
    .cpl_o           (cpl_q),
    .pre_fault_o     (pre_fault),
    .done_o          (res_valid_o)
  );

  gd_decode i_decode (
    .desc_i (desc),
    .gate_o (gate)
  );

  gd_check i_check (
    .gate_i      (gate),
    .src_i       (src_q),
    .cpl_i       (cpl_q),
    .pre_fault_i (pre_fault),
    .res_o       (res)
  );

  assign res_fault_o       = res.fault;
  assign res_fault_vec_o   = res.fvec;
  assign res_selector_o    = res.sel;
  assign res_offset_o      = res.off;
  assign res_if_clear_o    = res.if_clear;
  assign res_task_switch_o = res.task_sw;

  assert_fault_clean_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_fault_o) |-> (res_selector_o == '0 && res_offset_o == '0
                                      && !res_if_clear_o && !res_task_switch_o));

  assert_fault_code_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_fault_o) |-> (res_fault_vec_o == 8'd11 || res_fault_vec_o == 8'd13));

  assert_flag_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !(res_if_clear_o && res_task_switch_o));
endmodule

// File: tb/test_gate_dispatch.sv
`timescale 1ns/1ps
module test_gate_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_vec = '0;
  logic [1:0]  req_src = '0;
  logic [1:0]  req_cpl = '0;
  logic [31:0] base = 32'h0001_0000;
  logic [15:0] limit = 16'h07FF;
  logic        mreq_valid, mreq_ready = 1'b1;
  logic [31:0] maddr;
  logic        mrsp_valid = 1'b0;
  logic [31:0] mrsp_data = '0;
  logic        res_valid, res_fault, res_ifc, res_task;
  logic [7:0]  res_fvec;
  logic [15:0] res_sel;
  logic [31:0] res_off;

  int compared = 0, mismatched = 0;
  bit stall = 0;
  logic [63:0] tab [0:255];
  int beats = 0;
  logic [31:0] beat_addr [0:1];
  bit pending = 0;
  logic [31:0] pend_addr;

  always #5 clk = ~clk;

  gate_dispatch i_gate_dispatch (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vector_i(req_vec), .req_src_i(req_src), .req_cpl_i(req_cpl),
    .tbl_base_i(base), .tbl_limit_i(limit),
    .mem_req_valid_o(mreq_valid), .mem_req_ready_i(mreq_ready), .mem_addr_o(maddr),
    .mem_rsp_valid_i(mrsp_valid), .mem_rsp_data_i(mrsp_data),
    .res_valid_o(res_valid), .res_fault_o(res_fault), .res_fault_vec_o(res_fvec),
    .res_selector_o(res_sel), .res_offset_o(res_off),
    .res_if_clear_o(res_ifc), .res_task_switch_o(res_task)
  );

  function automatic logic [31:0] mem_word(logic [31:0] a);
    logic [31:0] d = a - base;
    if (d[1:0] != 2'b00 || d >= 32'd2048) return 32'hDEAD_BEEF;
    return d[2] ? tab[d[10:3]][63:32] : tab[d[10:3]][31:0];
  endfunction

  // memory model: beat accepted at a posedge, answered one cycle later
  always @(negedge clk) begin
    mrsp_valid = 1'b0;
    if (pending) begin
      mrsp_valid = 1'b1;
      mrsp_data  = mem_word(pend_addr);
      pending    = 0;
    end
    mreq_ready = stall ? ~mreq_ready : 1'b1;
    if (mreq_valid && mreq_ready) begin
      pending   = 1;
      pend_addr = maddr;
      if (beats < 2) beat_addr[beats] = maddr;
      beats++;
    end
  end

  function automatic logic [63:0] mk(logic [15:0] sel, logic [31:0] off, logic [3:0] typ,
                                     logic [1:0] dpl, logic p);
    return {off[31:16], p, dpl, 1'b0, typ, 8'h00, sel, off[15:0]};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // issue one lookup and compare all outputs against a model of the requirements
  task automatic verify(string tag, logic [7:0] v, logic [1:0] s, logic [1:0] c);
    logic [63:0] d = tab[v];
    logic [3:0] t = d[43:40];
    bit ok_t = (d[44] == 1'b0) && (t == 4'h5 || t == 4'h6 || t == 4'hE || t == 4'h7 || t == 4'hF);
    bit pre = ({21'd0, v, 3'b111} > {16'd0, limit}) || (s == 2'd1 && v < 8'd32);
    bit f; logic [7:0] fv; int eb;
    int n = 0;
    f = 1; fv = 8'd13;
    if (pre || !ok_t || (s == 2'd0 && c > d[46:45])) fv = 8'd13;
    else if (!d[47]) fv = 8'd11;
    else f = 0;
    eb = pre ? 0 : 2;
    @(negedge clk);
    chk(tag, "idle ready", {31'd0, req_ready}, 32'd1);
    beats = 0;
    req_valid = 1; req_vec = v; req_src = s; req_cpl = c;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!res_valid && n < 200) begin @(negedge clk); n++; end
    chk(tag, "valid", {31'd0, res_valid}, 32'd1);
    chk(tag, "fault", {31'd0, res_fault}, {31'd0, f});
    chk(tag, "fvec",  {24'd0, res_fvec}, f ? {24'd0, fv} : 32'd0);
    chk(tag, "sel",   {16'd0, res_sel}, f ? 32'd0 : {16'd0, d[31:16]});
    chk(tag, "off",   res_off, f ? 32'd0 : {d[63:48], d[15:0]});
    chk(tag, "ifclr", {31'd0, res_ifc}, (!f && (t == 4'h6 || t == 4'hE)) ? 32'd1 : 32'd0);
    chk(tag, "task",  {31'd0, res_task}, (!f && t == 4'h5) ? 32'd1 : 32'd0);
    chk(tag, "beats", beats, eb);
    if (eb == 2) begin
      chk(tag, "addr0", beat_addr[0], base + {21'd0, v, 3'b000});
      chk(tag, "addr1", beat_addr[1], base + {21'd0, v, 3'b100});
    end
    @(negedge clk);
    chk(tag, "pulse R12", {31'd0, res_valid}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", "reset ready", {31'd0, req_ready}, 32'd1);
    chk("R12", "reset valid", {31'd0, res_valid}, 32'd0);
    chk("R2", "reset mreq", {31'd0, mreq_valid}, 32'd0);
  endtask

  task automatic t_int_gate();  // R3 R4 R2
    tab[8'h30] = mk(16'h0008, 32'h1234_5678, 4'hE, 2'd0, 1'b1);
    tab[8'h31] = mk(16'h0010, 32'hCAFE_0001, 4'h6, 2'd0, 1'b1);
    verify("R4", 8'h30, 2'd1, 2'd3);
    verify("R3", 8'h31, 2'd2, 2'd0);
  endtask

  task automatic t_trap_gate();  // R5
    tab[8'h80] = mk(16'h001B, 32'h8000_4321, 4'hF, 2'd3, 1'b1);
    tab[8'h81] = mk(16'h0023, 32'h0000_FFFF, 4'h7, 2'd3, 1'b1);
    verify("R5", 8'h80, 2'd0, 2'd3);
    verify("R5", 8'h81, 2'd0, 2'd1);
  endtask

  task automatic t_task_gate();  // R6
    tab[8'h40] = mk(16'h0048, 32'hA5A5_5A5A, 4'h5, 2'd0, 1'b1);
    verify("R6", 8'h40, 2'd1, 2'd0);
  endtask

  task automatic t_bad_type();  // R7
    tab[8'h41] = mk(16'h0008, 32'h1, 4'hC, 2'd3, 1'b1);
    tab[8'h42] = mk(16'h0008, 32'h1, 4'hE, 2'd3, 1'b1) | (64'd1 << 44);
    verify("R7", 8'h41, 2'd0, 2'd0);
    verify("R7", 8'h42, 2'd2, 2'd0);
  endtask

  task automatic t_priv();  // R8
    tab[8'h50] = mk(16'h0008, 32'h0000_2000, 4'hE, 2'd0, 1'b1);
    verify("R8", 8'h50, 2'd0, 2'd3);
    verify("R8", 8'h50, 2'd1, 2'd3);
    verify("R8", 8'h50, 2'd2, 2'd3);
    verify("R8", 8'h50, 2'd0, 2'd0);
  endtask

  task automatic t_not_present();  // R11
    tab[8'h51] = mk(16'h0008, 32'h0000_3000, 4'hF, 2'd3, 1'b0);
    tab[8'h52] = mk(16'h0008, 32'h0000_3000, 4'hF, 2'd0, 1'b0);
    verify("R11", 8'h51, 2'd0, 2'd3);
    verify("R11", 8'h52, 2'd0, 2'd3);
  endtask

  task automatic t_limit();  // R9
    tab[8'h10] = mk(16'h0030, 32'h0BAD_F00D, 4'hE, 2'd0, 1'b1);
    tab[8'h11] = mk(16'h0030, 32'h0BAD_F00D, 4'hE, 2'd0, 1'b1);
    limit = 16'h0087;
    verify("R9", 8'h10, 2'd2, 2'd0);
    verify("R9", 8'h11, 2'd2, 2'd0);
    limit = 16'h0086;
    verify("R9", 8'h10, 2'd2, 2'd0);
    limit = 16'h07FF;
  endtask

  task automatic t_reserved();  // R10
    tab[8'h05] = mk(16'h0008, 32'h0000_0500, 4'hE, 2'd0, 1'b1);
    verify("R10", 8'h05, 2'd1, 2'd0);
    verify("R10", 8'h05, 2'd2, 2'd0);
    verify("R10", 8'h20, 2'd1, 2'd0);
  endtask

  task automatic t_stall_base();  // R2 with back-pressure and another base
    base = 32'h00C0_0100;
    stall = 1;
    verify("R2", 8'h30, 2'd1, 2'd0);
    verify("R2", 8'hFF, 2'd2, 2'd0);
    stall = 0;
    base = 32'h0001_0000;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) tab[i] = 64'd0;
    tab[8'h20] = mk(16'h0008, 32'h0000_2020, 4'hE, 2'd0, 1'b1);
    tab[8'hFF] = mk(16'hFFF8, 32'hFFFF_0000, 4'h7, 2'd0, 1'b1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_int_gate();
    t_trap_gate();
    t_task_gate();
    t_bad_type();
    t_priv();
    t_not_present();
    t_limit();
    t_reserved();
    t_stall_base();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule